// File: doc/BRIEF.md
# Presettable Binary Down Counter

The block is a binary down counter, eight bits wide by default, with one active-low terminal-count output. A clock edge moves the count down by one while the active-low count enable is held low. A clocked preset loads a parallel word on the next edge. An asynchronous preset forces the same word into the register at once. A master reset forces the register to all-ones.

The terminal-count output is decoded from the register and the enable without a clock. It goes low for a whole clock period when the count is zero and counting is enabled. Several counters can be chained this way. In the synchronous arrangement all stages share one clock, and each stage's terminal-count output drives the enable of the next, more significant stage.

The asynchronous preset is built per bit from an asynchronous set and an asynchronous clear. It therefore maps onto flops that have both. The parallel count value is also brought out so that the register can be observed.

Top module: `dcnt8`

## Requirements
- R1: While `rst_ni` is low, `count_o` is all-ones (255) at once, with no clock needed. This overrides every other input, including `aload_ni`.
- R2: On a rising edge with `en_ni` low, `sload_ni` high and no asynchronous control active, `count_o` decreases by exactly one.
- R3: On a rising edge with `en_ni` high and `sload_ni` high, `count_o` keeps its value.
- R4: `tc_no` is low exactly when `count_o` is zero and `en_ni` is low. It follows a change on `en_ni` between clock edges, without waiting for a clock edge.
- R5: On a rising edge with `sload_ni` low, `count_o` takes `preset_i`, whatever the level of `en_ni`.
- R6: While `aload_ni` is low and `rst_ni` is high, `count_o` equals `preset_i` at once. This holds whatever `sload_ni`, `en_ni` and the clock do.
- R7: Releasing `aload_ni` leaves the loaded value in place. The next enabled edge counts down from it.
- R8: An enabled edge at count zero wraps the count to 255.
- R9: In a two-stage synchronous chain, the upper stage's enable is the lower stage's `tc_no` and both stages share one clock. The upper stage then moves down by one once for every 256 enabled edges of the lower stage, and its `tc_no` is low only when both stages are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Count clock, rising edge |
| rst_ni | input | 1 | Master reset, active low, asynchronous, forces all-ones |
| en_ni | input | 1 | Count enable, active low |
| sload_ni | input | 1 | Clocked preset, active low |
| aload_ni | input | 1 | Asynchronous preset, active low |
| preset_i | input | W (8) | Parallel preset word |
| count_o | output | W (8) | Present count value |
| tc_no | output | 1 | Terminal count, active low |

## Verification
The clocked properties assume that `aload_ni` and `rst_ni` are asserted, and then released, with at least one rising edge in between, and that they change only away from a clock edge. A load that begins and ends between two edges would change the count under a next-cycle check that was never disabled. The stimulus drives every input just after a falling edge. It holds each asynchronous control low across one or more rising edges. It changes `preset_i` under an active asynchronous preset only while that preset is held.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_DEC  = 2'd1,
    OP_LOAD = 2'd2
  } dcnt_op_e;

  // clocked-path priority: preset over count
  function automatic dcnt_op_e pick_op(input logic sload_n, input logic en_n);
    if (!sload_n)   return OP_LOAD;
    else if (!en_n) return OP_DEC;
    else            return OP_HOLD;
  endfunction
endpackage

// File: rtl/dcnt_next.sv
module dcnt_next
  import dcnt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] preset_i,
  input  logic         sload_ni,
  input  logic         en_ni,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  dcnt_op_e op;

  always_comb begin
    op = pick_op(sload_ni, en_ni);
    unique case (op)
      OP_LOAD: nxt_o = preset_i;
      OP_DEC:  nxt_o = cur_i - ONE;  // wraps 0 -> all-ones
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/dcnt_bit.sv
module dcnt_bit (
  input  logic clk_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or posedge set_i or posedge clr_i) begin
    if (set_i)      q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/dcnt_tc.sv
module dcnt_tc #(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic         en_ni,
  output logic         tc_no
);
  always_comb tc_no = ~((cnt_i == '0) & ~en_ni);
endmodule

// File: rtl/dcnt8.sv
module dcnt8 #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic         sload_ni,
  input  logic         aload_ni,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] count_o,
  output logic         tc_no
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] set_b;
  logic [W-1:0] clr_b;

  dcnt_next #(.W(W)) u_next (
    .cur_i    (cnt_q),
    .preset_i (preset_i),
    .sload_ni (sload_ni),
    .en_ni    (en_ni),
    .nxt_o    (cnt_d)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    // reset wins; async preset splits into per-bit set or clear
    always_comb begin
      set_b[i] = ~rst_ni | (~aload_ni & preset_i[i]);
      clr_b[i] = rst_ni & ~aload_ni & ~preset_i[i];
    end

    dcnt_bit u_bit (
      .clk_i (clk_i),
      .set_i (set_b[i]),
      .clr_i (clr_b[i]),
      .d_i   (cnt_d[i]),
      .q_o   (cnt_q[i])
    );
  end

  dcnt_tc #(.W(W)) u_tc (
    .cnt_i (cnt_q),
    .en_ni (en_ni),
    .tc_no (tc_no)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/dcnt8_chk.sv
module dcnt8_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_ni,
  input logic         sload_ni,
  input logic         aload_ni,
  input logic [W-1:0] preset_i,
  input logic [W-1:0] count_o,
  input logic         tc_no
);
  localparam logic [W-1:0] ALL1 = '1;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  assert_reset_full_R1: assert property (@(posedge clk_i)
    !rst_ni |-> count_o == ALL1);

  assert_dec_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !aload_ni)
    (sload_ni && !en_ni) |=> count_o == $past(count_o) - ONE);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !aload_ni)
    (sload_ni && en_ni) |=> $stable(count_o));

  assert_tc_decode_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    tc_no == !(count_o == '0 && !en_ni));

  assert_sync_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !aload_ni)
    !sload_ni |=> count_o == $past(preset_i));

  assert_async_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aload_ni |-> count_o == preset_i);

  assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || !aload_ni)
    (sload_ni && !en_ni && count_o == '0) |=> count_o == ALL1);
endmodule

bind dcnt8 dcnt8_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_ni    (en_ni),
  .sload_ni (sload_ni),
  .aload_ni (aload_ni),
  .preset_i (preset_i),
  .count_o  (count_o),
  .tc_no    (tc_no)
);

// File: tb/dcnt8_test.sv
module dcnt8_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       en_ni = 1'b1;
  logic       sload_ni = 1'b1;
  logic       aload_ni = 1'b1;
  logic [7:0] preset = 8'h00;
  logic [7:0] count;
  logic       tc_n;

  logic       hi_sload_ni = 1'b1;
  logic [7:0] hi_preset = 8'h00;
  logic [7:0] hi_count;
  logic       hi_tc_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dcnt8 #(.W(8)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_ni(en_ni), .sload_ni(sload_ni),
    .aload_ni(aload_ni), .preset_i(preset), .count_o(count), .tc_no(tc_n)
  );

  // upper stage of a synchronous chain
  dcnt8 #(.W(8)) u_hi (
    .clk_i(clk), .rst_ni(rst_ni), .en_ni(tc_n), .sload_ni(hi_sload_ni),
    .aload_ni(1'b1), .preset_i(hi_preset), .count_o(hi_count), .tc_no(hi_tc_n)
  );

  // {sload_n, en_n, preset, exp_count, exp_tc_n}
  typedef logic [18:0] vec_t;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    {1'b1, 1'b0, 8'h00, 8'd254, 1'b1},  // R2
    {1'b1, 1'b0, 8'h00, 8'd253, 1'b1},  // R2
    {1'b1, 1'b1, 8'h00, 8'd253, 1'b1},  // R3
    {1'b0, 1'b1, 8'h05, 8'd5,   1'b1},  // R5 load with enable off
    {1'b1, 1'b0, 8'h00, 8'd4,   1'b1},  // R2
    {1'b0, 1'b0, 8'h01, 8'd1,   1'b1},  // R5 load wins over count
    {1'b1, 1'b0, 8'h00, 8'd0,   1'b0},  // R4 zero and enabled
    {1'b1, 1'b0, 8'h00, 8'd255, 1'b1},  // R8 wrap
    {1'b0, 1'b1, 8'h00, 8'd0,   1'b1},  // R4 zero but disabled
    {1'b1, 1'b1, 8'h00, 8'd0,   1'b1},  // R3
    {1'b0, 1'b0, 8'h80, 8'h80,  1'b1},  // R5
    {1'b1, 1'b0, 8'h00, 8'h7f,  1'b1}   // R2
  };

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2 rst_ni = 1'b0;
    #1;
    chk8("R1 count in reset", count, 8'd255);
    chk1("R1 tc in reset", tc_n, 1'b1);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sload_ni = VECS[i][18];
      en_ni    = VECS[i][17];
      preset   = VECS[i][16:9];
      tick();
      chk8($sformatf("vec%0d count", i), count, VECS[i][8:1]);
      chk1($sformatf("vec%0d tc", i), tc_n, VECS[i][0]);
    end

    // R4: tc follows enable between edges
    @(negedge clk);
    sload_ni = 1'b0; en_ni = 1'b1; preset = 8'h00;
    tick();
    @(negedge clk);
    sload_ni = 1'b1;
    #1 chk1("R4 zero, disabled", tc_n, 1'b1);
    en_ni = 1'b0;
    #1 chk1("R4 enable low, no edge", tc_n, 1'b0);
    en_ni = 1'b1;
    #1 chk1("R4 enable high, no edge", tc_n, 1'b1);

    // R6: async preset immediate, beats clocked preset and enable
    @(negedge clk);
    #1 preset = 8'h3c; aload_ni = 1'b0;
    #1 chk8("R6 immediate", count, 8'h3c);
    sload_ni = 1'b0; en_ni = 1'b0; preset = 8'h3c;
    tick(); tick();
    chk8("R6 held over edges", count, 8'h3c);
    @(negedge clk);
    preset = 8'hc3;
    #1 chk8("R6 follows preset", count, 8'hc3);

    // R1 over async preset
    rst_ni = 1'b0;
    #1 chk8("R1 beats async preset", count, 8'd255);
    tick();
    @(negedge clk);
    rst_ni = 1'b1;
    tick();
    @(negedge clk);
    sload_ni = 1'b1; en_ni = 1'b1;
    aload_ni = 1'b1;
    tick();
    chk8("R7 value kept on release", count, 8'hc3);
    @(negedge clk);
    en_ni = 1'b0;
    tick();
    chk8("R7 counts from loaded", count, 8'hc2);

    // R9: two-stage chain, start at 3*256+2
    @(negedge clk);
    en_ni = 1'b1; sload_ni = 1'b0; preset = 8'd2;
    hi_sload_ni = 1'b0; hi_preset = 8'd3;
    tick();
    @(negedge clk);
    sload_ni = 1'b1; hi_sload_ni = 1'b1; en_ni = 1'b0;
    for (int k = 0; k < 3; k++) tick();
    chk8("R9 low after borrow", count, 8'd255);
    chk8("R9 high after borrow", hi_count, 8'd2);
    for (int k = 0; k < 256; k++) tick();
    chk8("R9 low after 256", count, 8'd255);
    chk8("R9 high after 256", hi_count, 8'd1);
    chk1("R9 high tc not yet", hi_tc_n, 1'b1);
    for (int k = 0; k < 511; k++) tick();
    chk8("R9 low at zero", count, 8'd0);
    chk8("R9 high at zero", hi_count, 8'd0);
    chk1("R9 chain terminal", hi_tc_n, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule